// File: doc/BRIEF.md
# Programmable Timemark Delay Counter

This block produces the once-per-second timing pulse of a satellite-navigation receiver. A raw timemark strobe arrives once every ten periodic TIC events. The block delays it by a programmed number of sample-clock cycles, where one count is 25 ns, and then drives an output pulse. The nominal delay is 40000 counts (1 ms). Software moves that value up or down to remove the receiver clock offset.

Software writes the 22-bit delay in two parts. A low register holds bits 15:0. A high register holds bits 21:16 in its bits 5:0 and an enable flag in bit 6. Writing the high register with the flag set captures the whole value and arms the block. Each accepted timemark uses up the arming. When the accumulated correction grows past a full TIC, software skips one re-arm. The next raw timemark then gives no pulse, and the following event runs with the smaller, rolled-over delay.

The register writes and the strobe are plain control pins with no handshake. The block never stalls its inputs, so there is no back-pressure: a strobe that cannot be served is dropped and recorded in the overrun flag.

Top module: `tmark_delay_gen`

## Requirements
- R1: A synchronous reset clears the pulse output, the armed flag, the overrun flag, the countdown and the stored low half.
- R2: A low-register write (`wr_hi`=0) only stores bits 15:0 and does not arm. A high-register write with `wr_data[6]`=1 arms the block with the delay `{wr_data[5:0], low}`. For example, low 0x0018 with high 0x41 gives 65560.
- R3: A high-register write with `wr_data[6]`=0 leaves the block unarmed.
- R4: An accepted raw timemark sampled at clock edge k makes `pulse_out` rise after edge k+D, where D is the armed delay. A delay of 0 acts as 1.
- R5: Each pulse stays high for exactly PULSE_W clock cycles. The default is 1.
- R6: Accepting a timemark clears the armed flag. A later raw timemark with no fresh high write in between gives no pulse, so that TIC is skipped.
- R7: A raw timemark that arrives while unarmed, or while a countdown or pulse is in progress, is dropped. It leaves the pending armed value untouched and sets `overrun`, which stays set until reset.
- R8: If a high write and a raw timemark fall in the same cycle, the timemark uses the earlier arming and the write arms again for the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (one count per cycle) |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | 0 selects low register, 1 selects high register |
| wr_data | input | 16 | Write data |
| raw_mark | input | 1 | Raw timemark strobe, one cycle |
| pulse_out | output | 1 | Delayed timing pulse |
| armed | output | 1 | A fresh delay is waiting for the next raw timemark |
| overrun | output | 1 | Sticky: a raw timemark was dropped |

## Verification
A stale armed flag would either make a pulse on an event that should be skipped, or lose the skip, and this shows at the output within one programmed delay. A wrong count shows as a pulse that is early or late by a number of cycles, which the bench measures exactly, including over the full 40000- and 65560-cycle delays. A busy indication that stays high or drops too early shows on the next strobe: either `overrun` changes state or a second pulse appears.

// File: rtl/tmd_pkg.sv
package tmd_pkg;
  localparam int DLY_W   = 22;
  localparam int LO_W    = 16;
  localparam int HI_W    = DLY_W - LO_W;
  localparam int FLAG_IX = 6;
  typedef logic [DLY_W-1:0] delay_t;
endpackage

// File: rtl/tmd_regs.sv
module tmd_regs
  import tmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [15:0] wr_data,
  input  logic        take,
  output logic        armed,
  output delay_t      delay
);
  logic [LO_W-1:0] lo_q;
  logic            arm_wr;

  assign arm_wr = wr_en && wr_hi && wr_data[FLAG_IX];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      delay <= '0;
      armed <= 1'b0;
    end else begin
      if (wr_en && !wr_hi) lo_q <= wr_data[LO_W-1:0];
      if (arm_wr) begin
        delay <= {wr_data[HI_W-1:0], lo_q};
        armed <= 1'b1;
      end else if (wr_en && wr_hi) begin
        armed <= 1'b0;
      end else if (take) begin
        armed <= 1'b0;
      end
    end
  end

  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (rst) arm_wr |=> armed);
  // R3
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_hi && !wr_data[FLAG_IX]) |=> !armed);
  // R6
  take_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !(wr_en && wr_hi)) |=> !armed);
endmodule

// File: rtl/tmd_count.sv
module tmd_count
  import tmd_pkg::*;
#(
  parameter int PULSE_W = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  delay_t load_val,
  output logic   busy,
  output logic   pulse
);
  localparam int PW_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  delay_t          cnt;
  logic            running;
  logic [PW_W-1:0] pw_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
      pulse   <= 1'b0;
      pw_cnt  <= '0;
    end else begin
      if (start) begin
        cnt     <= load_val;
        running <= 1'b1;
      end else if (running) begin
        if (cnt <= delay_t'(1)) begin
          running <= 1'b0;
          pulse   <= 1'b1;
          pw_cnt  <= PW_W'(PULSE_W - 1);
        end else begin
          cnt <= cnt - delay_t'(1);
        end
      end
      if (pulse) begin
        if (pw_cnt == '0) pulse  <= 1'b0;
        else              pw_cnt <= pw_cnt - PW_W'(1);
      end
    end
  end

  assign busy = running || pulse;

  // R4
  pulse_after_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(running));
  // R7
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(start && busy));
endmodule

// File: rtl/tmark_delay_gen.sv
module tmark_delay_gen
  import tmd_pkg::*;
#(
  parameter int PULSE_W = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [15:0] wr_data,
  input  logic        raw_mark,
  output logic        pulse_out,
  output logic        armed,
  output logic        overrun
);
  delay_t dly;
  logic   busy, take;

  assign take = raw_mark && armed && !busy;

  tmd_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .take(take), .armed(armed), .delay(dly)
  );

  tmd_count #(.PULSE_W(PULSE_W)) u_count (
    .clk(clk), .rst(rst), .start(take), .load_val(dly),
    .busy(busy), .pulse(pulse_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                  overrun <= 1'b0;
    else if (raw_mark && !take) overrun <= 1'b1;
  end

  // R7
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(raw_mark));
  // R1
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: tb/tb_tmark_delay_gen.sv
module tb_tmark_delay_gen;
  localparam int PW = 1;
  logic clk = 0, rst = 1, wr_en = 0, wr_hi = 0, raw_mark = 0;
  logic [15:0] wr_data = '0;
  logic pulse_out, armed, overrun;

  tmark_delay_gen #(.PULSE_W(PW)) dut (.*);

  always #5 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int unsigned expq[$];
  logic prev_p = 0;
  int hi_len = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected rise cycles and measures widths.
  always @(negedge clk) begin
    if (pulse_out && !prev_p) begin
      if (expq.size() == 0) chk(0, "R6 unexpected pulse", cyc, -1);
      else begin
        int unsigned e;
        e = expq.pop_front();
        chk(cyc == e, "R4 pulse cycle", cyc, e);
      end
      hi_len = 1;
    end else if (pulse_out) hi_len++;
    else if (prev_p) chk(hi_len == PW, "R5 pulse width", hi_len, PW);
    prev_p = pulse_out;
  end

  task automatic wr(input bit hi, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic mark(input int d, input bit expect_pulse);
    @(negedge clk); raw_mark = 1;
    if (expect_pulse) expq.push_back(cyc + 1 + ((d < 1) ? 1 : d));
    @(negedge clk); raw_mark = 0;
  endtask

  task automatic settle();
    for (int i = 0; i < 70000 && (expq.size() != 0 || pulse_out); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R4 missing pulse", expq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk); rst = 0;
    chk(!pulse_out && !armed && !overrun, "R1 reset state", {pulse_out, armed, overrun}, 0);
    // low alone does not arm
    wr(0, 16'd5);
    chk(!armed, "R2 low write no arm", armed, 0);
    mark(0, 0); settle();
    chk(overrun, "R7 unarmed drop", overrun, 1);
    do_reset();
    chk(!overrun && !armed, "R1 reset clears", {overrun, armed}, 0);
    // basic arm and fire, D=5
    wr(0, 16'd5); wr(1, 16'h0040);
    chk(armed, "R2 arm on high write", armed, 1);
    mark(5, 1); settle();
    chk(!armed, "R6 consumed", armed, 0);
    chk(!overrun, "R7 no false overrun", overrun, 0);
    // skip: raw with no re-arm
    mark(0, 0); settle();
    chk(overrun, "R6 skipped event flagged", overrun, 1);
    do_reset();
    // zero delay acts as one
    wr(0, 16'd0); wr(1, 16'h0040); mark(0, 1); settle();
    // busy drop
    wr(0, 16'd20); wr(1, 16'h0040); mark(20, 1);
    wr(0, 16'd3); wr(1, 16'h0040);
    mark(0, 0);
    chk(overrun, "R7 busy drop", overrun, 1);
    chk(armed, "R7 arming kept", armed, 1);
    settle();
    mark(3, 1); settle();
    // flag clear
    wr(0, 16'd9); wr(1, 16'h0040); wr(1, 16'h0005);
    chk(!armed, "R3 flag clear disarms", armed, 0);
    // same-cycle write and raw
    wr(0, 16'd4); wr(1, 16'h0040); wr(0, 16'd7);
    @(negedge clk); raw_mark = 1; wr_en = 1; wr_hi = 1; wr_data = 16'h0040;
    expq.push_back(cyc + 1 + 4);
    @(negedge clk); raw_mark = 0; wr_en = 0;
    chk(armed, "R8 re-armed", armed, 1);
    settle();
    mark(7, 1); settle();
    // nominal and wide values
    wr(0, 16'h9C40); wr(1, 16'h0040); mark(40000, 1); settle();
    wr(0, 16'h0018); wr(1, 16'h0041); mark(65560, 1); settle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    chk(0, "R4 watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule